// File: doc/BRIEF.md
# Packed SIMD Integer Add/Subtract Unit

This block adds or subtracts two 64-bit operands that are treated as a row of independent integer lanes. Software picks the lane width for each operation: eight byte lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed at the same time, and no carry or borrow passes from one lane into the next.

Each operation also picks how a lane treats a result that does not fit. In wraparound mode the excess bits are dropped. In unsigned saturating mode the lane is held at all ones or at zero. In signed saturating mode the lane is held at the largest positive or the most negative two's-complement value.

The lane results are captured in one output register. They appear together with a valid flag on the clock edge after the edge that accepted the operands. The block is meant to sit in the execute stage of a media or signal-processing pipeline, after the operand fetch.

Top module: `psimd_addsub`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W]. No carry or borrow crosses a lane boundary.
- R2: `mode_sel` value 0 or 3 selects wraparound. The carry or borrow out of each lane is discarded, so the byte sum 0xA0 + 0x70 gives 0x10.
- R3: `mode_sel` value 2 selects unsigned saturation. An addition that overflows a lane gives all ones in that lane. A subtraction that underflows a lane gives zero.
- R4: `mode_sel` value 1 selects signed saturation. A lane that overflows in the positive direction gives 0x7F, 0x7FFF or 0x7FFFFFFF, depending on lane width. A lane that overflows in the negative direction gives 0x80, 0x8000 or 0x80000000.
- R5: `sub_en` = 0 computes `op_a` + `op_b` in each lane. `sub_en` = 1 computes `op_a` − `op_b` in each lane. Both directions use the same three overflow modes.
- R6: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. In that cycle `out_data` holds the result for the operands accepted on that edge.
- R7: While `in_valid` is low, `out_data` keeps its previous value.
- R8: A synchronous reset clears both `out_valid` and `out_data` to zero.
- R9: With signed byte saturation, 0x8080555580805555 + 0x009033FF009033FF gives 0x80807F5480807F54.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_a | input | 64 | First operand (minuend for subtraction) |
| op_b | input | 64 | Second operand (subtrahend for subtraction) |
| lane_sel | input | 2 | Lane width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| mode_sel | input | 2 | 0 or 3 = wrap, 1 = signed saturate, 2 = unsigned saturate |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 64 | Registered packed result |

## Verification
The assertions assume that `rst` is held for at least one edge before any check is made. They also assume that `lane_sel`, `mode_sel` and `sub_en` are stable and known whenever `in_valid` is high, because every per-lane clamp event is decoded from those controls in the same cycle. The stimulus meets both assumptions. It changes all inputs only on the falling clock edge, and it applies reset before the first operation. It then sweeps every combination of lane width, direction and mode code, including the two alias codes, with boundary lane values (zero, one, largest positive, most negative, all ones) and with random operands.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  typedef enum logic [1:0] {
    LW_8    = 2'd0,
    LW_16   = 2'd1,
    LW_32   = 2'd2,
    LW_32_B = 2'd3
  } lane_w_t;

  typedef enum logic [1:0] {
    OV_WRAP   = 2'd0,
    OV_SSAT   = 2'd1,
    OV_USAT   = 2'd2,
    OV_WRAP_B = 2'd3
  } ovf_mode_t;

  localparam int NUM_WIDTHS = 3;

  // lane width in bits for bank index g (8, 16, 32)
  function automatic int bank_width(input int g);
    return 8 << g;
  endfunction

endpackage

// File: rtl/psimd_lane.sv
module psimd_lane
  import psimd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  ovf_mode_t    mode,
  output logic [W-1:0] res,
  output logic         clip_hi,
  output logic         clip_lo
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  // raw lane sum with carry-out; subtraction as a + ~b + 1
  function automatic logic [W:0] lane_sum(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         neg);
    logic [W-1:0] yy;
    yy = neg ? ~y : y;
    return {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, neg};
  endfunction

  // signed overflow: operands agree in sign, result disagrees
  function automatic logic signed_ovf(input logic sa, input logic sb_eff,
                                      input logic sr);
    return (sa == sb_eff) && (sr != sa);
  endfunction

  logic [W:0]   sum;
  logic [W-1:0] raw;
  logic         carry;
  logic         s_ovf;
  logic         u_ovf;

  always_comb begin
    sum   = lane_sum(a, b, sub);
    raw   = sum[W-1:0];
    carry = sum[W];
    s_ovf = signed_ovf(a[W-1], b[W-1] ^ sub, raw[W-1]);
    u_ovf = sub ? ~carry : carry;

    clip_hi = 1'b0;
    clip_lo = 1'b0;
    unique case (mode)
      OV_SSAT: begin
        clip_hi = s_ovf & ~a[W-1];
        clip_lo = s_ovf &  a[W-1];
      end
      OV_USAT: begin
        clip_hi = u_ovf & ~sub;
        clip_lo = u_ovf &  sub;
      end
      default: ;
    endcase

    if (clip_hi)
      res = (mode == OV_SSAT) ? S_MAX : {W{1'b1}};
    else if (clip_lo)
      res = (mode == OV_SSAT) ? S_MIN : {W{1'b0}};
    else
      res = raw;
  end

endmodule

// File: rtl/psimd_bank.sv
module psimd_bank
  import psimd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int W      = 8
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                sub,
  input  ovf_mode_t           mode,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W/8-1:0] clip_hi,
  output logic [DATA_W/8-1:0] clip_lo
);

  localparam int LANES = DATA_W / W;
  localparam int BPL   = W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hi_k;
    logic lo_k;
    psimd_lane #(.W(W)) lane_i (
      .a       (a[k*W +: W]),
      .b       (b[k*W +: W]),
      .sub     (sub),
      .mode    (mode),
      .res     (res[k*W +: W]),
      .clip_hi (hi_k),
      .clip_lo (lo_k)
    );
    // spread each lane event over the bytes it covers
    assign clip_hi[k*BPL +: BPL] = {BPL{hi_k}};
    assign clip_lo[k*BPL +: BPL] = {BPL{lo_k}};
  end

endmodule

// File: rtl/psimd_stage.sv
module psimd_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic              q_valid,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/psimd_addsub.sv
module psimd_addsub
  import psimd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_sel,
  input  logic              sub_en,
  input  logic [1:0]        mode_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int BYTES = DATA_W / 8;

  ovf_mode_t mode;
  lane_w_t   lw;
  assign mode = ovf_mode_t'(mode_sel);
  assign lw   = lane_w_t'(lane_sel);

  logic [DATA_W-1:0] bank_res [NUM_WIDTHS];
  logic [BYTES-1:0]  bank_hi  [NUM_WIDTHS];
  logic [BYTES-1:0]  bank_lo  [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_bank
    psimd_bank #(.DATA_W(DATA_W), .W(bank_width(g))) bank_i (
      .a       (op_a),
      .b       (op_b),
      .sub     (sub_en),
      .mode    (mode),
      .res     (bank_res[g]),
      .clip_hi (bank_hi[g]),
      .clip_lo (bank_lo[g])
    );
  end

  // selected result and per-byte clamp events, brought out for checking
  logic [DATA_W-1:0] next_data;
  logic [BYTES-1:0]  lane_clip_hi;
  logic [BYTES-1:0]  lane_clip_lo;

  always_comb begin
    unique case (lw)
      LW_8: begin
        next_data    = bank_res[0];
        lane_clip_hi = bank_hi[0];
        lane_clip_lo = bank_lo[0];
      end
      LW_16: begin
        next_data    = bank_res[1];
        lane_clip_hi = bank_hi[1];
        lane_clip_lo = bank_lo[1];
      end
      default: begin
        next_data    = bank_res[2];
        lane_clip_hi = bank_hi[2];
        lane_clip_lo = bank_lo[2];
      end
    endcase
  end

  psimd_stage #(.DATA_W(DATA_W)) stage_i (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (next_data),
    .q_valid (out_valid),
    .q       (out_data)
  );

endmodule

// File: rtl/psimd_addsub_chk.sv
module psimd_addsub_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              sub_en,
  input logic [1:0]        mode_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W/8-1:0] lane_clip_hi,
  input logic [DATA_W/8-1:0] lane_clip_lo
);

  // R6: valid follows the accepted strobe by one cycle
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7: held output while idle
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R2: wraparound never raises a clamp event
  assert_wrap_no_clip_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode_sel == 2'd0 || mode_sel == 2'd3)) |->
      (lane_clip_hi == '0 && lane_clip_lo == '0));

  // R3/R4: a lane cannot clamp both ways at once
  assert_clip_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((lane_clip_hi & lane_clip_lo) == '0));

  // R5: adding or subtracting zero leaves the operand unchanged
  assert_zero_identity_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_b == '0) |=> out_data == $past(op_a));

  // R5: x - x is zero in every mode
  assert_self_sub_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_en && op_a == op_b) |=> out_data == '0);

endmodule

bind psimd_addsub psimd_addsub_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .op_a         (op_a),
  .op_b         (op_b),
  .sub_en       (sub_en),
  .mode_sel     (mode_sel),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .lane_clip_hi (lane_clip_hi),
  .lane_clip_lo (lane_clip_lo)
);

// File: tb/psimd_addsub_tb.sv
module psimd_addsub_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        sub_en = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_vec  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  psimd_addsub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_sel(lane_sel), .sub_en(sub_en), .mode_sel(mode_sel),
    .out_valid(out_valid), .out_data(out_data)
  );

  // arithmetic reference, lane by lane with wide integers
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] ls, input logic sb,
                                        input logic [1:0] md);
    int w;
    logic [63:0] r;
    longint msk, ua, ub, sa, sbv, v, lo, hi;
    w   = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    msk = (longint'(1) << w) - 1;
    r   = '0;
    for (int k = 0; k < 64 / w; k++) begin
      ua  = longint'((a >> (k * w)) & 64'(msk));
      ub  = longint'((b >> (k * w)) & 64'(msk));
      sa  = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
      sbv = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
      if (md == 2'd1) begin
        v  = sb ? sa - sbv : sa + sbv;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        if (v > hi) v = hi;
        if (v < lo) v = lo;
      end else begin
        v = sb ? ua - ub : ua + ub;
        if (md == 2'd2) begin
          if (v > msk) v = msk;
          if (v < 0)   v = 0;
        end
      end
      r = r | ((64'(v) & 64'(msk)) << (k * w));
    end
    return r;
  endfunction

  function automatic longint edge_val(input int idx, input int w);
    longint m;
    m = (longint'(1) << w) - 1;
    case (idx)
      0: return 0;
      1: return m >> 1;
      2: return longint'(1) << (w - 1);
      3: return m;
      default: return 1;
    endcase
  endfunction

  function automatic logic [63:0] edge_word(input int i0, input int w);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 64 / w; k++)
      r = r | (64'(edge_val((i0 + k) % 5, w)) << (k * w));
    return r;
  endfunction

  // drive on falling edge, check on the next falling edge
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] ls, input logic sb, input logic [1:0] md,
                        input string tag);
    logic [63:0] exp;
    exp = model(a, b, ls, sb, md);
    op_a = a; op_b = b; lane_sel = ls; sub_en = sb; mode_sel = md;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_vec++;
    if (out_valid !== 1'b1 || out_data !== exp) begin
      n_fail++;
      $display("FAIL %s ls=%0d sub=%0d md=%0d a=%h b=%h act=%h/%b exp=%h/1",
               tag, ls, sb, md, a, b, out_data, out_valid, exp);
    end
  endtask

  task automatic check_eq(input logic [63:0] act, input logic [63:0] exp,
                          input string tag);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'd1: return "R1/R4/R5";
      2'd2: return "R1/R3/R5";
      default: return "R1/R2/R5";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check_eq({63'd0, out_valid}, 64'd0, "R8 valid after reset");
    check_eq(out_data, 64'd0, "R8 data after reset");
    rst = 1'b0;

    // R9: signed byte saturation example
    run_op(64'h8080555580805555, 64'h009033FF009033FF, 2'd0, 1'b0, 2'd1, "R9");
    check_eq(out_data, 64'h80807F5480807F54, "R9 literal");

    // R2: wrap literal, carry dropped, neighbour lane untouched (R1)
    run_op(64'h00000000000000A0, 64'h0000000000000070, 2'd0, 1'b0, 2'd0, "R2");
    check_eq(out_data, 64'h0000000000000010, "R2 literal R1 no carry");

    // R7: output holds while idle; R6: valid drops
    repeat (3) @(negedge clk);
    check_eq(out_data, 64'h0000000000000010, "R7 hold");
    check_eq({63'd0, out_valid}, 64'd0, "R6 valid low when idle");

    // sweeps: all widths, directions, mode codes
    for (int ls = 0; ls < 4; ls++)
      for (int md = 0; md < 4; md++)
        for (int sb = 0; sb < 2; sb++) begin
          int w;
          w = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              run_op(edge_word(i, w), edge_word(j, w), 2'(ls), 1'(sb), 2'(md),
                     mode_tag(2'(md)));
          for (int r = 0; r < 30; r++)
            run_op({$urandom(), $urandom()}, {$urandom(), $urandom()},
                   2'(ls), 1'(sb), 2'(md), mode_tag(2'(md)));
        end

    // R8: reset mid-run clears the registers
    rst = 1'b1;
    @(negedge clk);
    check_eq(out_data, 64'd0, "R8 data after late reset");
    check_eq({63'd0, out_valid}, 64'd0, "R8 valid after late reset");
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule